// File: doc/BRIEF.md
# Multi-mode per-channel input debounce filter

This block conditions the demodulated bits that arrive from a bank of isolated digital field inputs, before firmware reads them as switch or sensor states. Each low-speed channel passes through a short always-on prefilter and then through a configurable stage. That stage removes chatter in one of three ways: by waiting for a steady level, by integrating up and down, or by taking the first edge and then ignoring the input for a while. Channels that are marked high-speed at elaboration skip both stages, so their edges reach the output with no delay.

All timing runs from a one-microsecond tick enable, so the filter delays are counts of ticks. The four delay settings scale with `TICKS_PER_MS`. A power-good input gates the bank. While it is low, every output is zero and every counter is cleared. Once power-good has been held for `STARTUP_US` ticks, the outputs start to follow their filtered inputs. A parameter selects a fixed-configuration build. In that build, every low-speed channel runs the steady-level filter with one common delay, and the configuration inputs have no effect.

Top module: `field_debounce_bank`

## Requirements
- R1: Every low-speed channel has a prefilter that changes level only after the raw input has held a new level for `PRE_US` consecutive ticks. A shorter pulse never reaches the output. A pulse of exactly `PRE_US` ticks does reach it.
- R2: The delay code `cfg_delay[2i+1:2i]` maps to D = 0, 10, 30 or 100 ms for codes 00, 01, 10 and 11, where 1 ms is `TICKS_PER_MS` ticks. In steady-level mode, a clean step appears at the output `PRE_US + max(D,1)` ticks after the raw input changes.
- R3: In steady-level mode (mode code 00), any reversal of the prefiltered input before D ticks have passed restarts the count from zero.
- R4: In integrating mode (mode code 01), a counter rises on each tick where the prefiltered input differs from the output and falls on each tick where they match. The output toggles when the counter reaches D. After H high ticks, G low ticks and then a steady high, the output rises `PRE_US + D - H + G` ticks after the final rise.
- R5: In blanking mode (mode code 10), the output takes a new level one tick after the prefilter delivers it. The input is then ignored for D ticks, and the output resamples on the following tick. A falling edge issued straight after a rise therefore appears `max(D+1, PRE_US+1)` ticks later when D is not 0.
- R6: A channel whose bit is set in `HS_MASK` drives its output combinationally from its raw input whenever the bank runs.
- R7: Mode and delay are chosen per channel, and channels do not affect each other. Mode code 11 behaves as steady-level mode.
- R8: A change to a channel's mode or delay code clears that channel's counter on the next clock edge. Its output level is kept.
- R9: While `power_good` is low, every output is 0. Outputs are enabled `STARTUP_US` ticks after `power_good` rises. Filtering then begins from cleared counters.
- R10: With `FIXED_CFG` set, every low-speed channel uses steady-level mode with delay code `FIXED_DLY`, whatever the configuration inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle enable, once per microsecond |
| power_good | input | 1 | Supply-good indication; low forces outputs to 0 |
| raw_in | input | NUM_CH | Demodulated raw channel bits, synchronous to clk |
| cfg_mode | input | 2*NUM_CH | Per-channel filter mode code, two bits per channel |
| cfg_delay | input | 2*NUM_CH | Per-channel delay code, two bits per channel |
| dout | output | NUM_CH | Filtered channel outputs |

## Verification
The bench sweeps every mode code against every delay code with clean rising and falling steps, and compares each latency with a value worked out arithmetically. The sweep separates blanking, which responds at once and holds for the window, from the counting modes. It also checks the code-to-delay scaling. One glitched pattern, high for 30 ticks, low for 6 ticks, then high, tells the restarting filter apart from the integrating one. A disturbance inside a blanking window shows that the window ignores its input. Prefilter pulses of 3 and 4 ticks probe the boundary of the prefilter. Staggered configurations on three channels at once, a configuration change in the middle of a count, power-good sequencing, the high-speed bypass and the fixed-configuration build cover the remaining requirements.

// File: rtl/fdb_pkg.sv
package fdb_pkg;

   typedef enum logic [1:0] {
      MD_STEADY = 2'b00,
      MD_INTEG  = 2'b01,
      MD_BLANK  = 2'b10,
      MD_SPARE  = 2'b11
   } fdb_mode_e;

   // delay code to tick count: 00 none, 01 10 ms, 10 30 ms, 11 100 ms
   function automatic int unsigned delay_ticks(logic [1:0] code, int unsigned tpm);
      case (code)
         2'b00:   return 0;
         2'b01:   return 10 * tpm;
         2'b10:   return 30 * tpm;
         default: return 100 * tpm;
      endcase
   endfunction

endpackage

// File: rtl/fdb_prefilter.sv
module fdb_prefilter #(
   parameter int PRE_US = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clr,
   input  logic din,
   output logic dout
);
   localparam int PW = $clog2(PRE_US + 1);

   logic [PW-1:0] pcnt;
   logic [PW:0]   pcnt_inc;
   logic          pf;

   assign pcnt_inc = {1'b0, pcnt} + {{PW{1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
         pf   <= 1'b0;
      end else if (clr) begin
         pcnt <= '0;
         pf   <= 1'b0;
      end else if (tick) begin
         if (din == pf) begin
            pcnt <= '0;
         end else if (pcnt_inc >= (PW+1)'(PRE_US)) begin
            pf   <= din;
            pcnt <= '0;
         end else begin
            pcnt <= pcnt_inc[PW-1:0];
         end
      end
   end

   assign dout = pf;

   // R1: the prefiltered level moves only on the last tick of a full hold
   a_r1_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(clr) && pf != $past(pf)) |-> ($past(pcnt) == PW'(PRE_US - 1)));

endmodule

// File: rtl/fdb_stage.sv
module fdb_stage
   import fdb_pkg::*;
#(
   parameter int CW  = 17,
   parameter int TPM = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       clr,
   input  logic [1:0] mode,
   input  logic [1:0] dcode,
   input  logic       din,
   output logic       dout
);
   logic [CW-1:0] cnt;
   logic [CW:0]   cnt_inc;
   logic [CW-1:0] dval;
   logic [3:0]    cfg_q;
   logic          chg;
   logic          hit;
   logic          q;

   assign dval    = CW'(delay_ticks(dcode, TPM));
   assign cnt_inc = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
   assign hit     = cnt_inc >= {1'b0, dval};
   assign chg     = cfg_q != {mode, dcode};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= {mode, dcode};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         q   <= 1'b0;
      end else if (clr) begin
         cnt <= '0;
         q   <= 1'b0;
      end else if (chg) begin
         cnt <= '0;
      end else if (tick) begin
         case (fdb_mode_e'(mode))
            MD_BLANK: begin
               if (cnt != '0) begin
                  cnt <= cnt - 1'b1;
               end else if (din != q) begin
                  q   <= din;
                  cnt <= dval;
               end
            end
            MD_INTEG: begin
               if (din != q) begin
                  if (hit) begin
                     q   <= din;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt_inc[CW-1:0];
                  end
               end else if (cnt != '0) begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: begin
               if (din == q) begin
                  cnt <= '0;
               end else if (hit) begin
                  q   <= din;
                  cnt <= '0;
               end else begin
                  cnt <= cnt_inc[CW-1:0];
               end
            end
         endcase
      end
   end

   assign dout = q;

   // R2: counting modes change level only when the count has reached the delay
   a_r2_toggle_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) != 2'b10 && !$past(clr) && !$past(chg) && q != $past(q)) |-> $past(hit));

   // R5: no level change while a blanking window is open
   a_r5_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == 2'b10 && !$past(clr) && !$past(chg) && $past(cnt) != '0) |-> $stable(q));

   // R4: the integrator never runs past the configured delay
   a_r4_integ_bound: assert property (@(posedge clk) disable iff (!rst_n)
      !chg |-> (cnt <= dval));

   // R8: a configuration change leaves a cleared counter behind
   a_r8_cfg_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (chg && !clr) |=> (cnt == '0 && q == $past(q)));

endmodule

// File: rtl/fdb_startup.sv
module fdb_startup #(
   parameter int STARTUP_US = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic power_good,
   output logic run
);
   localparam int SW = $clog2(STARTUP_US + 1);

   logic [SW-1:0] scnt;
   logic [SW:0]   scnt_inc;
   logic          started;

   assign scnt_inc = {1'b0, scnt} + {{SW{1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scnt    <= '0;
         started <= 1'b0;
      end else if (!power_good) begin
         scnt    <= '0;
         started <= 1'b0;
      end else if (!started && tick) begin
         if (scnt_inc >= (SW+1)'(STARTUP_US)) started <= 1'b1;
         else                                 scnt    <= scnt_inc[SW-1:0];
      end
   end

   assign run = started & power_good;

   // R9: enable comes only after the full hold of power-good
   a_r9_start_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(started) |-> ($past(scnt) == SW'(STARTUP_US - 1) && $past(power_good)));

   // R9: losing power-good drops the enable on the next edge
   a_r9_pg_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !power_good |=> !started);

endmodule

// File: rtl/field_debounce_bank.sv
module field_debounce_bank
   import fdb_pkg::*;
#(
   parameter int               NUM_CH       = 8,
   parameter int               TICKS_PER_MS = 1000,
   parameter int               PRE_US       = 4,
   parameter int               STARTUP_US   = 1000,
   parameter logic [NUM_CH-1:0] HS_MASK     = '0,
   parameter bit               FIXED_CFG    = 1'b0,
   parameter logic [1:0]       FIXED_DLY    = 2'b00
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                us_tick,
   input  logic                power_good,
   input  logic [NUM_CH-1:0]   raw_in,
   input  logic [2*NUM_CH-1:0] cfg_mode,
   input  logic [2*NUM_CH-1:0] cfg_delay,
   output logic [NUM_CH-1:0]   dout
);
   localparam int CW = $clog2(100 * TICKS_PER_MS + 1);

   if (NUM_CH < 1)       begin : g_bad_ch  $error("NUM_CH must be at least 1");       end
   if (PRE_US < 1)       begin : g_bad_pre $error("PRE_US must be at least 1");       end
   if (STARTUP_US < 1)   begin : g_bad_st  $error("STARTUP_US must be at least 1");   end
   if (TICKS_PER_MS < 1) begin : g_bad_tpm $error("TICKS_PER_MS must be at least 1"); end

   logic run;

   fdb_startup #(.STARTUP_US(STARTUP_US)) u_startup (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (us_tick),
      .power_good (power_good),
      .run        (run)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      if (HS_MASK[i]) begin : g_fast
         assign dout[i] = run & raw_in[i];
      end else begin : g_slow
         logic       pf;
         logic       filt;
         logic [1:0] mode_eff;
         logic [1:0] dly_eff;

         if (FIXED_CFG) begin : g_fixed
            assign mode_eff = 2'b00;
            assign dly_eff  = FIXED_DLY;
         end else begin : g_cfg
            assign mode_eff = cfg_mode[2*i +: 2];
            assign dly_eff  = cfg_delay[2*i +: 2];
         end

         fdb_prefilter #(.PRE_US(PRE_US)) u_pre (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (us_tick),
            .clr   (!run),
            .din   (raw_in[i]),
            .dout  (pf)
         );

         fdb_stage #(.CW(CW), .TPM(TICKS_PER_MS)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (us_tick),
            .clr   (!run),
            .mode  (mode_eff),
            .dcode (dly_eff),
            .din   (pf),
            .dout  (filt)
         );

         assign dout[i] = run & filt;

         // R9: a held-off bank produces no high output on the next edge either
         a_r9_slow_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !run |=> !filt);
      end
   end

endmodule

// File: tb/test_field_debounce_bank.sv
module test_field_debounce_bank;
   localparam int CLK_PERIOD = 10;
   localparam int N     = 8;
   localparam int TPM   = 4;
   localparam int PRE   = 4;
   localparam int START = 20;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           us_tick;
   logic           power_good;
   logic [N-1:0]   raw_in;
   logic [2*N-1:0] cfg_mode;
   logic [2*N-1:0] cfg_delay;
   logic [N-1:0]   dout;
   logic [N-1:0]   dout_f;

   always #(CLK_PERIOD/2) clk = ~clk;

   field_debounce_bank #(
      .NUM_CH(N), .TICKS_PER_MS(TPM), .PRE_US(PRE), .STARTUP_US(START),
      .HS_MASK(8'h80)
   ) i_field_debounce_bank (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .power_good(power_good),
      .raw_in(raw_in), .cfg_mode(cfg_mode), .cfg_delay(cfg_delay), .dout(dout)
   );

   field_debounce_bank #(
      .NUM_CH(N), .TICKS_PER_MS(TPM), .PRE_US(PRE), .STARTUP_US(START),
      .HS_MASK(8'h80), .FIXED_CFG(1'b1), .FIXED_DLY(2'b01)
   ) i_field_debounce_bank_fixed (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .power_good(power_good),
      .raw_in(raw_in), .cfg_mode({N{2'b10}}), .cfg_delay({2*N{1'b0}}), .dout(dout_f)
   );

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int dly(int code);
      case (code)
         0:       return 0;
         1:       return 10 * TPM;
         2:       return 30 * TPM;
         default: return 100 * TPM;
      endcase
   endfunction

   function automatic int imax(int a, int b);
      return (a > b) ? a : b;
   endfunction

   task automatic meas(int ch, bit fixed, logic lvl, int maxc, output int n);
      n = 0;
      while (((fixed ? dout_f[ch] : dout[ch]) !== lvl) && n < maxc) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
   endtask

   task automatic setcfg(int ch, int m, int d);
      cfg_mode[2*ch +: 2]  = 2'(m);
      cfg_delay[2*ch +: 2] = 2'(d);
      repeat (2) @(negedge clk);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int n, n2, n3, bad, seen, exp_r, exp_f, d, t0, t1, t2;
      string tag;
      rst_n      = 1'b0;
      us_tick    = 1'b1;
      power_good = 1'b0;
      raw_in     = '1;
      cfg_mode   = '0;
      cfg_delay  = '0;
      idle(5);
      rst_n = 1'b1;

      // R9: nothing leaves the bank while power-good is low
      bad = 0;
      for (int c = 0; c < 30; c++) begin
         @(negedge clk);
         if (dout != '0 || dout_f != '0) bad++;
      end
      chk("R9 outputs low before power-good", bad, 0);

      // R9/R6: high-speed channel enabled after the startup hold
      power_good = 1'b1;
      meas(7, 1'b0, 1'b1, 200, n);
      chk("R9 startup hold", n, START);
      // R1/R9: low-speed channel starts filtering from cleared state
      meas(0, 1'b0, 1'b1, 200, n2);
      chk("R9 first low-speed rise", n + n2, START + PRE + 1);
      // R10: fixed build uses steady mode with 10 ms delay despite blanking codes
      meas(0, 1'b1, 1'b1, 400, n3);
      chk("R10 fixed build latency", n + n2 + n3, START + PRE + dly(1));

      // R9: power-good loss drops every output at once
      power_good = 1'b0;
      #1;
      chk("R9 outputs on power-good loss", int'(dout), 0);
      idle(3);
      raw_in     = '0;
      power_good = 1'b1;
      idle(START + 10);
      chk("R9 settled low after restart", int'(dout), 0);

      // R6: combinational bypass on the high-speed channel
      raw_in[7] = 1'b1;
      #1;
      chk("R6 bypass high", int'(dout[7]), 1);
      @(negedge clk);
      raw_in[7] = 1'b0;
      #1;
      chk("R6 bypass low", int'(dout[7]), 0);
      @(negedge clk);

      // R1: prefilter boundary, 3-tick pulse blocked, 4-tick pulse passed
      setcfg(0, 0, 0);
      raw_in[0] = 1'b1;
      idle(3);
      raw_in[0] = 1'b0;
      seen = 0;
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         if (dout[0]) seen = 1;
      end
      chk("R1 short pulse blocked", seen, 0);
      raw_in[0] = 1'b1;
      idle(4);
      raw_in[0] = 1'b0;
      seen = 0;
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         if (dout[0]) seen = 1;
      end
      chk("R1 full-length pulse passed", seen, 1);
      idle(10);

      // R2/R5/R7: sweep all mode codes against all delay codes
      for (int m = 0; m < 4; m++) begin
         for (int dc = 0; dc < 4; dc++) begin
            d = dly(dc);
            if (m == 2) begin
               tag   = "R5";
               exp_r = PRE + 1;
               exp_f = (d == 0) ? PRE + 1 : imax(d + 1, PRE + 1);
            end else begin
               tag   = (m == 3) ? "R7" : (m == 1) ? "R4" : "R2";
               exp_r = PRE + imax(d, 1);
               exp_f = PRE + imax(d, 1);
            end
            setcfg(0, m, dc);
            raw_in[0] = 1'b1;
            meas(0, 1'b0, 1'b1, 1000, n);
            chk($sformatf("%s rise mode=%0d delay=%0d", tag, m, dc), n, exp_r);
            raw_in[0] = 1'b0;
            meas(0, 1'b0, 1'b0, 1000, n);
            chk($sformatf("%s fall mode=%0d delay=%0d", tag, m, dc), n, exp_f);
         end
      end

      // R3 and R4: high 30, low 6, then steady high, 10 ms delay
      for (int m = 0; m < 2; m++) begin
         setcfg(0, m, 1);
         raw_in[0] = 1'b1;
         idle(30);
         raw_in[0] = 1'b0;
         idle(6);
         chk(m == 0 ? "R3 held low through glitch" : "R4 held low through glitch",
             int'(dout[0]), 0);
         raw_in[0] = 1'b1;
         meas(0, 1'b0, 1'b1, 1000, n);
         if (m == 0) chk("R3 restart after reversal", n, PRE + dly(1));
         else        chk("R4 integrator credit", n, PRE + dly(1) - 30 + 6);
         raw_in[0] = 1'b0;
         idle(100);
      end

      // R5: disturbance inside the blanking window is ignored
      setcfg(0, 2, 1);
      raw_in[0] = 1'b1;
      meas(0, 1'b0, 1'b1, 100, n);
      chk("R5 immediate edge", n, PRE + 1);
      bad = 0;
      for (int c = 0; c < 50; c++) begin
         if (c == 5)  raw_in[0] = 1'b0;
         if (c == 13) raw_in[0] = 1'b1;
         @(negedge clk);
         if (!dout[0]) bad++;
      end
      chk("R5 window ignores input", bad, 0);
      raw_in[0] = 1'b0;
      meas(0, 1'b0, 1'b0, 100, n);
      chk("R5 resample after window", n, PRE + 1);
      idle(60);

      // R8: configuration change mid-count clears the counter
      setcfg(0, 0, 1);
      raw_in[0] = 1'b1;
      idle(30);
      cfg_mode[1:0] = 2'b01;
      meas(0, 1'b0, 1'b1, 1000, n);
      chk("R8 count restarts on config change", n, dly(1) + 1);
      raw_in[0] = 1'b0;
      idle(100);

      // R7: three channels with different settings respond independently
      setcfg(0, 0, 1);
      setcfg(1, 0, 0);
      setcfg(2, 1, 2);
      raw_in[2:0] = 3'b111;
      t0 = -1; t1 = -1; t2 = -1;
      for (int c = 1; c <= 200; c++) begin
         @(posedge clk);
         @(negedge clk);
         if (dout[0] && t0 < 0) t0 = c;
         if (dout[1] && t1 < 0) t1 = c;
         if (dout[2] && t2 < 0) t2 = c;
      end
      chk("R7 channel 1 no delay", t1, PRE + 1);
      chk("R7 channel 0 10 ms", t0, PRE + dly(1));
      chk("R7 channel 2 30 ms integrating", t2, PRE + dly(2));
      raw_in = '0;
      idle(10);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule